// File: doc/BRIEF.md
# Sequential Buffer Address Pointer

This block keeps the 13-bit word address for the sequential port of an 8K-word memory that is split into two buffers. On every rising edge of the sequential clock the pointer either holds, steps forward by one, jumps to one of two programmed start addresses, or takes an arbitrary address that was presented on the sequential data pins one cycle earlier. A small write port programs the start and end address of each buffer. When a counting pointer reaches a buffer's end address, it returns to that buffer's start address.

A direct address load goes through a staging register. On the sampling edge the data pins are captured and the pointer does not move. On the following edge the pointer takes the staged address. Count enable is ignored on both of these edges. The read path is told through `data_ready` that data at the new address is not yet valid. A start-strobe load completes in one edge and does not drop `data_ready`.

A three-state machine sequences the pointer:
- RUN is the normal state.
- PEND means a direct address is staged.
- WAIT is the one cycle after the staged address has been applied.

The transitions are:
- load-sample: RUN or WAIT to PEND, when the direct-load input is low.
- apply: PEND to WAIT, when direct-load is high again.
- reload: PEND to PEND, when direct-load stays low. The staged address is applied and a new one is captured.
- settle: WAIT to RUN.
- run-stay: RUN to RUN in every other case.

Top module: `seq_addr_pointer`

## Requirements
- R1: A synchronous active-low reset sets the pointer, the staging register and all four start/end registers to 0. It also enters state RUN (`data_ready` high) and clears both error flags.
- R2: On an edge where `ld_n` is low and the block is not in PEND, `sio[12:0]` is captured into the staging register. The pointer keeps its value even if `cnt_en` is high.
- R3: On the edge after a direct-load sample, the pointer takes the staged address whatever `cnt_en` is.
- R4: With no direct load active, `strt1_n` low loads start address 1 on the next edge, and `strt2_n` low loads start address 2. When both are low, start address 1 wins.
- R5: A start strobe that is low while `ld_n` is low, or in the cycle after a direct-load sample, is ignored in favour of the direct load. `illegal_strobe` is high for the cycle after that edge.
- R6: `data_ready` is low after the sampling edge and after the following apply edge of a direct load. It is high again one edge later. After a start-strobe load it stays high.
- R7: When `ld_n` is sampled low while any of `sio[15:13]` is 0, `addr_hi_err` is high for the following cycle.
- R8: When counting and not at an end address, the pointer increments by one per edge and wraps from 8191 to 0.
- R9: When counting and the pointer equals end address 1, the pointer loads start address 1. Otherwise, when it equals end address 2, it loads start address 2. The end address 1 compare is checked first.
- R10: `cfg_we` high writes `cfg_wdata` on the next edge to one register, selected by `cfg_addr`: 0 is start 1, 1 is end 1, 2 is start 2 and 3 is end 2.
- R11: With `cnt_en` low and no load requested, the pointer holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequential clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_n | input | 1 | Direct address load request, active low |
| strt1_n | input | 1 | Buffer 1 start strobe, active low |
| strt2_n | input | 1 | Buffer 2 start strobe, active low |
| cnt_en | input | 1 | Count enable |
| sio | input | 16 | Sequential data pins; [12:0] carry the address, [15:13] must be high during a load |
| cfg_we | input | 1 | Start/end register write enable |
| cfg_addr | input | 2 | Start/end register select |
| cfg_wdata | input | 13 | Start/end register write data |
| ptr | output | 13 | Current pointer |
| data_ready | output | 1 | Read data at the pointer is valid |
| illegal_strobe | output | 1 | A start strobe collided with a direct load on the previous edge |
| addr_hi_err | output | 1 | Upper data pins were not all high on the previous direct-load sample |

## Verification
On every cycle, assertions check the following:
- the pointer is frozen on the sampling edge;
- the staged value appears on the apply edge;
- `data_ready` is low after the apply edge;
- the two error flags follow their triggering conditions;
- the counter wraps at the top of the address space;
- the state stays one-hot.

Only the bench's scenarios show the rest. These are:
- the priority between the two strobes and the end-address compares;
- that a colliding strobe really loses to the staged address;
- that register writes land in the selected slot;
- that the pointer follows a long mixed sequence of loads, strobes and counting.

// File: rtl/seqptr_pkg.sv
package seqptr_pkg;
    typedef enum logic [2:0] {
        ST_RUN  = 3'b001,
        ST_PEND = 3'b010,
        ST_WAIT = 3'b100
    } ptr_state_t;

    typedef enum logic [2:0] {
        SEL_HOLD,
        SEL_STAGE,
        SEL_START1,
        SEL_START2,
        SEL_COUNT
    } ptr_sel_t;

    localparam int NUM_PRESETS = 4;
    localparam logic [1:0] CFG_START1 = 2'd0;
    localparam logic [1:0] CFG_END1   = 2'd1;
    localparam logic [1:0] CFG_START2 = 2'd2;
    localparam logic [1:0] CFG_END2   = 2'd3;
endpackage

// File: rtl/seqptr_presets.sv
module seqptr_presets #(
    parameter int AW = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [1:0]    waddr,
    input  logic [AW-1:0] wdata,
    output logic [AW-1:0] start1,
    output logic [AW-1:0] end1,
    output logic [AW-1:0] start2,
    output logic [AW-1:0] end2
);
    import seqptr_pkg::*;

    logic [AW-1:0] slot_q [NUM_PRESETS];

    for (genvar g = 0; g < NUM_PRESETS; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q[g] <= '0;
            end else if (we && waddr == 2'(g)) begin
                slot_q[g] <= wdata;
            end
        end
    end

    assign start1 = slot_q[CFG_START1];
    assign end1   = slot_q[CFG_END1];
    assign start2 = slot_q[CFG_START2];
    assign end2   = slot_q[CFG_END2];

    AST_CFG_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (we && waddr == CFG_END1) |=> (end1 == $past(wdata))) else $error("cfg write"); // R10
endmodule

// File: rtl/seqptr_ctrl.sv
module seqptr_ctrl (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ld_n,
    input  logic                   strt1_n,
    input  logic                   strt2_n,
    input  logic                   cnt_en,
    output seqptr_pkg::ptr_sel_t   sel,
    output logic                   capture,
    output logic                   collide,
    output logic                   data_ready,
    output seqptr_pkg::ptr_state_t state
);
    import seqptr_pkg::*;

    ptr_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d    = ST_RUN;
        sel        = SEL_HOLD;
        capture    = 1'b0;
        collide    = 1'b0;
        data_ready = (state_q == ST_RUN);
        unique case (state_q)
            ST_PEND: begin
                sel     = SEL_STAGE;
                capture = !ld_n;
                collide = !strt1_n || !strt2_n;
                state_d = ld_n ? ST_WAIT : ST_PEND;
            end
            ST_RUN, ST_WAIT: begin
                if (!ld_n) begin
                    capture = 1'b1;
                    collide = !strt1_n || !strt2_n;
                    state_d = ST_PEND;
                end else if (!strt1_n) begin
                    sel = SEL_START1;
                end else if (!strt2_n) begin
                    sel = SEL_START2;
                end else if (cnt_en) begin
                    sel = SEL_COUNT;
                end
            end
            default: state_d = ST_RUN;
        endcase
    end

    assign state = state_q;

    AST_STATE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(state_q)) else $error("state encoding"); // R1
    AST_NOT_READY_AFTER_APPLY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PEND && ld_n) |=> !data_ready) else $error("ready early"); // R6
    AST_READY_AFTER_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && ld_n) |=> data_ready) else $error("ready late"); // R6
endmodule

// File: rtl/seqptr_next.sv
module seqptr_next #(
    parameter int AW = 13
) (
    input  seqptr_pkg::ptr_sel_t sel,
    input  logic [AW-1:0]        cur,
    input  logic [AW-1:0]        staged,
    input  logic [AW-1:0]        start1,
    input  logic [AW-1:0]        end1,
    input  logic [AW-1:0]        start2,
    input  logic [AW-1:0]        end2,
    output logic [AW-1:0]        nxt
);
    import seqptr_pkg::*;

    always_comb begin
        nxt = cur;
        unique case (sel)
            SEL_HOLD:   nxt = cur;
            SEL_STAGE:  nxt = staged;
            SEL_START1: nxt = start1;
            SEL_START2: nxt = start2;
            SEL_COUNT: begin
                if (cur == end1) begin
                    nxt = start1;
                end else if (cur == end2) begin
                    nxt = start2;
                end else begin
                    nxt = cur + AW'(1);
                end
            end
            default: nxt = cur;
        endcase
    end
endmodule

// File: rtl/seq_addr_pointer.sv
module seq_addr_pointer #(
    parameter int AW = 13,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_n,
    input  logic          strt1_n,
    input  logic          strt2_n,
    input  logic          cnt_en,
    input  logic [DW-1:0] sio,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_addr,
    input  logic [AW-1:0] cfg_wdata,
    output logic [AW-1:0] ptr,
    output logic          data_ready,
    output logic          illegal_strobe,
    output logic          addr_hi_err
);
    import seqptr_pkg::*;

    localparam int HIW = DW - AW;

    logic [AW-1:0] ptr_q, stage_q, ptr_d;
    logic [AW-1:0] start1, end1, start2, end2;
    logic          capture, collide, ill_q, herr_q;
    ptr_sel_t      sel;
    ptr_state_t    state;

    seqptr_presets #(.AW(AW)) u_presets (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .waddr(cfg_addr), .wdata(cfg_wdata),
        .start1(start1), .end1(end1), .start2(start2), .end2(end2)
    );

    seqptr_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .ld_n(ld_n), .strt1_n(strt1_n), .strt2_n(strt2_n),
        .cnt_en(cnt_en), .sel(sel), .capture(capture), .collide(collide),
        .data_ready(data_ready), .state(state)
    );

    seqptr_next #(.AW(AW)) u_next (
        .sel(sel), .cur(ptr_q), .staged(stage_q), .start1(start1), .end1(end1),
        .start2(start2), .end2(end2), .nxt(ptr_d)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q   <= '0;
            stage_q <= '0;
            ill_q   <= 1'b0;
            herr_q  <= 1'b0;
        end else begin
            ptr_q  <= ptr_d;
            ill_q  <= collide;
            herr_q <= !ld_n && (sio[DW-1:AW] != {HIW{1'b1}});
            if (capture) begin
                stage_q <= sio[AW-1:0];
            end
        end
    end

    assign ptr            = ptr_q;
    assign illegal_strobe = ill_q;
    assign addr_hi_err    = herr_q;

    AST_FREEZE_ON_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_n && state != ST_PEND) |=> (ptr == $past(ptr))) else $error("moved on sample"); // R2
    AST_APPLY_STAGED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PEND) |=> (ptr == $past(stage_q))) else $error("stage not applied"); // R3
    AST_COLLIDE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_n && !strt1_n) |=> illegal_strobe) else $error("collision missed"); // R5
    AST_HI_BITS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_n && !sio[DW-1]) |=> addr_hi_err) else $error("hi bits missed"); // R7
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_COUNT && ptr == {AW{1'b1}} && end1 != {AW{1'b1}} && end2 != {AW{1'b1}})
        |=> (ptr == '0)) else $error("wrap"); // R8
endmodule

// File: tb/test_seq_addr_pointer.sv
`timescale 1ns/1ps
module test_seq_addr_pointer;
    logic        clk = 1'b0;
    logic        rst_n, ld_n, strt1_n, strt2_n, cnt_en, cfg_we;
    logic [15:0] sio;
    logic [1:0]  cfg_addr;
    logic [12:0] cfg_wdata;
    logic [12:0] ptr;
    logic        data_ready, illegal_strobe, addr_hi_err;

    int vectors = 0;
    int errors  = 0;

    logic [12:0] m_ptr, m_stage;
    logic [12:0] m_reg [4];
    int          m_st;
    logic        m_ill, m_herr;

    always #4 clk = ~clk;

    seq_addr_pointer i_seq_addr_pointer (
        .clk(clk), .rst_n(rst_n), .ld_n(ld_n), .strt1_n(strt1_n), .strt2_n(strt2_n),
        .cnt_en(cnt_en), .sio(sio), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .ptr(ptr), .data_ready(data_ready),
        .illegal_strobe(illegal_strobe), .addr_hi_err(addr_hi_err)
    );

    function automatic logic [12:0] count_next(logic [12:0] p);
        if (p == m_reg[1]) return m_reg[0];
        if (p == m_reg[2+1]) return m_reg[2];
        return p + 13'd1;
    endfunction

    task automatic model_edge();
        logic [12:0] np;
        logic [12:0] ns;
        int          nst;
        if (!rst_n) begin
            m_ptr = '0; m_stage = '0; m_st = 0; m_ill = 0; m_herr = 0;
            for (int i = 0; i < 4; i++) m_reg[i] = '0;
            return;
        end
        np = m_ptr; ns = m_stage; nst = 0;
        m_ill  = (!ld_n || m_st == 1) && (!strt1_n || !strt2_n);
        m_herr = !ld_n && (sio[15:13] != 3'b111);
        if (m_st == 1) begin
            np = m_stage;
            if (!ld_n) begin ns = sio[12:0]; nst = 1; end
            else nst = 2;
        end else if (!ld_n) begin
            ns = sio[12:0]; nst = 1;
        end else if (!strt1_n) np = m_reg[0];
        else if (!strt2_n) np = m_reg[2];
        else if (cnt_en) np = count_next(m_ptr);
        if (cfg_we) m_reg[cfg_addr] = cfg_wdata;
        m_ptr = np; m_stage = ns; m_st = nst;
    endtask

    task automatic chk(string tag, string what, int act, int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic step(string tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        chk(tag, "ptr", ptr, m_ptr);
        chk(tag, "data_ready", data_ready, (m_st == 0));
        chk(tag, "illegal_strobe", illegal_strobe, m_ill);
        chk(tag, "addr_hi_err", addr_hi_err, m_herr);
    endtask

    task automatic idle();
        ld_n = 1; strt1_n = 1; strt2_n = 1; cnt_en = 0; cfg_we = 0;
        sio = 16'hE000; cfg_addr = 0; cfg_wdata = 0;
    endtask

    task automatic cfg_write(logic [1:0] a, logic [12:0] d);
        idle(); cfg_we = 1; cfg_addr = a; cfg_wdata = d;
        step("R10");
        idle();
    endtask

    initial begin
        #(200000 * 8);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        idle();
        rst_n = 0;
        @(negedge clk);
        step("R1"); step("R1");
        rst_n = 1;

        cfg_write(0, 13'd100); cfg_write(1, 13'd110);
        cfg_write(2, 13'd4000); cfg_write(3, 13'd4005);

        strt1_n = 0; step("R4"); idle();
        cnt_en = 1;
        for (int i = 0; i < 12; i++) step("R9");
        idle(); strt2_n = 0; step("R4");
        strt1_n = 0; step("R4"); idle();

        ld_n = 0; cnt_en = 1; sio = 16'hE000 | 16'd8190; step("R2");
        ld_n = 1; step("R3");
        step("R6"); step("R8"); step("R8");

        idle(); step("R11"); step("R11");

        ld_n = 0; strt1_n = 0; sio = 16'hE000 | 16'd77; step("R5");
        ld_n = 1; strt1_n = 1; strt2_n = 0; step("R5");
        idle(); step("R6");

        ld_n = 0; sio = 16'h1234; step("R7");
        idle(); step("R7"); step("R6");

        for (int i = 0; i < 4000; i++) begin
            ld_n      = ($urandom_range(0, 7) != 0);
            strt1_n   = ($urandom_range(0, 9) != 0);
            strt2_n   = ($urandom_range(0, 9) != 0);
            cnt_en    = $urandom_range(0, 1);
            sio       = 16'($urandom);
            if ($urandom_range(0, 3) != 0) sio[15:13] = 3'b111;
            cfg_we    = ($urandom_range(0, 30) == 0);
            cfg_addr  = 2'($urandom);
            cfg_wdata = 13'($urandom);
            step("R8");
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule